// File: doc/BRIEF.md
# Write Strobe Qualifier

This block decides whether an incoming write strobe is allowed to start an internal programming cycle in a non-volatile memory controller. It watches a digital supply-good indication and three asynchronous active-low control levels: chip enable, output enable and write enable. It issues a single-cycle write-start pulse only when the supply is good, a power-on holdoff has fully elapsed, the control levels permit a write, and the strobe has stayed low long enough to rule out a noise glitch.

All four inputs are brought into the system clock domain through two-flop synchronisers. A write strobe is the interval during which chip enable and write enable are both low while output enable is high. Either strobe may be the last to fall. The strobe width is counted in clock cycles against a parameterised minimum. The holdoff counter starts again from zero every time the supply indication drops, so each power-up costs a full fresh delay.

Top module: `write_qualifier`

## Requirements
- R1: While the synchronised supply-good level is low, `writeStart` never asserts, whatever the strobes do.
- R2: After supply-good rises, no write starts until it has stayed high for HOLDOFF_CYCLES clock cycles. A strobe well after that delay starts a write.
- R3: A drop of supply-good, even a short one, discards any elapsed holdoff. A strobe right after the supply returns is blocked until a full new delay has passed.
- R4: While output enable is low (`oeN` = 0), no write starts even if both chip enable and write enable are low.
- R5: If chip enable stays high while write enable pulses low, no write starts. If write enable stays high while chip enable pulses low, no write starts either.
- R6: A strobe whose qualified low time lasts fewer than MIN_WIDTH clock cycles starts no write. A strobe of exactly MIN_WIDTH cycles starts one.
- R7: Each qualified strobe produces exactly one `writeStart` pulse, one clock cycle wide, however long the strobe is held. Once the strobe is released, the next strobe produces another pulse.
- R8: A write starts both when write enable falls last (chip enable already low) and when chip enable falls last (write enable already low).
- R9: The width count runs only over consecutive qualified cycles. If output enable goes low in the middle of a strobe, the count restarts from zero.
- R10: The inputs pass through two synchronising flops. While reset is active, and right after it, `writeStart` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyGood | input | 1 | Digital supply-good level, asynchronous |
| ceN | input | 1 | Active-low chip enable, asynchronous |
| oeN | input | 1 | Active-low output enable, asynchronous |
| weN | input | 1 | Active-low write enable, asynchronous |
| writeStart | output | 1 | One-cycle qualified write-start pulse |

## Verification
The embedded assertions check several rules on every cycle. They check that a start pulse is always preceded by an expired holdoff, output enable high and both strobes low. They check that the pulse never lasts two cycles, that a low supply clears the holdoff on the next edge, and that the width counter stays within its bound. Other behaviours depend on how long something lasts, and only the directed scenarios can show them. These are the exact width boundary, the restart after an output-enable dip, the full delay after a supply bounce, and one pulse per long strobe. Each scenario compares a count of pulses against the count the requirements predict.

// File: rtl/wrq_pkg.sv
package wrq_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic widthInc;
    logic widthClear;
    logic holdInc;
    logic holdClear;
  } wrqStrobes_t;

  // synchronised control levels
  typedef struct packed {
    logic sgS;
    logic ceS;
    logic oeS;
    logic weS;
  } wrqLevels_t;

endpackage

// File: rtl/wrq_sync.sv
module wrq_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[g] <= RESET_VAL;
          else       stageQ[g] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[g] <= RESET_VAL;
          else       stageQ[g] <= stageQ[g-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/wrq_datapath.sv
module wrq_datapath
  import wrq_pkg::*;
#(
  parameter int HOLDOFF_CYCLES = 250000,
  parameter int MIN_WIDTH = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  wrqStrobes_t stb,
  input  logic        sgS,
  output logic        holdoffDone,
  output logic        widthAtLast
);

  localparam int HOLD_W  = $clog2(HOLDOFF_CYCLES + 1);
  localparam int WIDTH_W = $clog2(MIN_WIDTH + 1);
  localparam logic [HOLD_W-1:0]  HOLD_LAST  = HOLD_W'(HOLDOFF_CYCLES - 1);
  localparam logic [WIDTH_W-1:0] WIDTH_LAST = WIDTH_W'(MIN_WIDTH - 1);

  logic [HOLD_W-1:0]  holdCnt;
  logic [WIDTH_W-1:0] widthCnt;

  // power-on holdoff timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt     <= '0;
      holdoffDone <= 1'b0;
    end else if (stb.holdClear) begin
      holdCnt     <= '0;
      holdoffDone <= 1'b0;
    end else if (stb.holdInc) begin
      if (holdCnt == HOLD_LAST) holdoffDone <= 1'b1;
      else                      holdCnt     <= holdCnt + 1'b1;
    end
  end

  // strobe width counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                widthCnt <= '0;
    else if (stb.widthClear)  widthCnt <= '0;
    else if (stb.widthInc && widthCnt != WIDTH_LAST) widthCnt <= widthCnt + 1'b1;
  end

  assign widthAtLast = (widthCnt == WIDTH_LAST);

  // R3: a low supply level clears the holdoff on the next edge
  assert_supply_drop_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    !sgS |=> !holdoffDone);

  // R6: width counter never passes its terminal value
  assert_width_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    widthCnt <= WIDTH_LAST);

  // R2: holdoff counter never passes its terminal value
  assert_hold_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= HOLD_LAST);

endmodule

// File: rtl/wrq_ctrl.sv
module wrq_ctrl
  import wrq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  wrqLevels_t  lvl,
  input  logic        holdoffDone,
  input  logic        widthAtLast,
  output wrqStrobes_t stb,
  output logic        writeStart
);

  logic strobeLow;
  logic qualified;
  logic fired;
  logic fireNow;

  assign strobeLow = !lvl.ceS && !lvl.weS;
  assign qualified = strobeLow && lvl.oeS && lvl.sgS && holdoffDone;
  assign fireNow   = qualified && !fired && widthAtLast;

  always_comb begin
    stb            = '0;
    stb.holdClear  = !lvl.sgS;
    stb.holdInc    = lvl.sgS && !holdoffDone;
    stb.widthInc   = qualified && !fired;
    stb.widthClear = !qualified || fired || fireNow;
  end

  // one pulse per strobe; re-armed once the strobe is released
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fired      <= 1'b0;
      writeStart <= 1'b0;
    end else begin
      writeStart <= fireNow;
      if (!strobeLow)  fired <= 1'b0;
      else if (fireNow) fired <= 1'b1;
    end
  end

  // R7: pulse is one cycle wide
  assert_single_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    writeStart |=> !writeStart);

  // R2 / R1: a start needs an expired holdoff and a good supply
  assert_holdoff_before_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    writeStart |-> $past(holdoffDone && lvl.sgS));

  // R4: output enable must have been high
  assert_oe_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    writeStart |-> $past(lvl.oeS));

  // R5: both strobes must have been low
  assert_both_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    writeStart |-> $past(!lvl.ceS && !lvl.weS));

endmodule

// File: rtl/write_qualifier.sv
module write_qualifier
  import wrq_pkg::*;
#(
  parameter int HOLDOFF_CYCLES = 250000,
  parameter int MIN_WIDTH = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyGood,
  input  logic ceN,
  input  logic oeN,
  input  logic weN,
  output logic writeStart
);

  wrqLevels_t  lvl;
  wrqStrobes_t stb;
  logic [3:0]  syncVec;
  logic        holdoffDone;
  logic        widthAtLast;

  wrq_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RESET_VAL(4'b0111)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({supplyGood, ceN, oeN, weN}),
    .syncOut(syncVec)
  );

  // levels are stored active-high for output enable (oeS = 1 means oeN high)
  assign lvl = '{sgS: syncVec[3], ceS: syncVec[2], oeS: syncVec[1], weS: syncVec[0]};

  wrq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lvl(lvl),
    .holdoffDone(holdoffDone), .widthAtLast(widthAtLast),
    .stb(stb), .writeStart(writeStart)
  );

  wrq_datapath #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES), .MIN_WIDTH(MIN_WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sgS(lvl.sgS),
    .holdoffDone(holdoffDone), .widthAtLast(widthAtLast)
  );

endmodule

// File: tb/sim_write_qualifier.sv
module sim_write_qualifier;

  localparam int HOLD = 40;
  localparam int MINW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyGood = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic writeStart;

  int checks = 0, fails = 0, pulses = 0, doubles = 0;
  logic prevWs = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  write_qualifier #(.HOLDOFF_CYCLES(HOLD), .MIN_WIDTH(MINW)) u0 (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood),
    .ceN(ceN), .oeN(oeN), .weN(weN), .writeStart(writeStart)
  );

  always @(negedge clk) begin
    if (writeStart) pulses++;
    if (writeStart && prevWs) doubles++;
    prevWs = writeStart;
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // both strobes low for lowLen cycles; ceLast picks which falls last
  task automatic strobe(input int lowLen, input bit ceLast);
    if (ceLast) weN = 1'b0; else ceN = 1'b0;
    cyc(1);
    if (ceLast) ceN = 1'b0; else weN = 1'b0;
    cyc(lowLen);
    weN = 1'b1; ceN = 1'b1;
    cyc(8);
  endtask

  task automatic t_reset();
    check("R10 reset output", int'(writeStart), 0);
    cyc(4);
    check("R10 no pulse after reset", pulses, 0);
  endtask

  task automatic t_unpowered();
    int p0 = pulses;
    strobe(10, 1'b0);
    check("R1 supply low blocks", pulses - p0, 0);
  endtask

  task automatic t_holdoff();
    int p0;
    supplyGood = 1'b1;
    cyc(3);
    p0 = pulses;
    strobe(10, 1'b0);
    check("R2 early strobe blocked", pulses - p0, 0);
    cyc(HOLD + 10);
    p0 = pulses;
    strobe(10, 1'b0);
    check("R2 strobe after holdoff", pulses - p0, 1);
  endtask

  task automatic t_width();
    int p0 = pulses;
    strobe(MINW - 1, 1'b0);
    check("R6 short strobe", pulses - p0, 0);
    p0 = pulses;
    strobe(1, 1'b0);
    check("R6 one-cycle glitch", pulses - p0, 0);
    p0 = pulses;
    strobe(MINW, 1'b0);
    check("R6 exact minimum", pulses - p0, 1);
  endtask

  task automatic t_long();
    int p0 = pulses;
    strobe(30, 1'b0);
    check("R7 long strobe one pulse", pulses - p0, 1);
    check("R7 pulse one cycle wide", doubles, 0);
    p0 = pulses;
    strobe(6, 1'b0);
    strobe(6, 1'b0);
    check("R7 two strobes two pulses", pulses - p0, 2);
  endtask

  task automatic t_order();
    int p0 = pulses;
    strobe(6, 1'b1);
    check("R8 chip enable falls last", pulses - p0, 1);
  endtask

  task automatic t_levels();
    int p0 = pulses;
    oeN = 1'b0;
    cyc(1);
    strobe(10, 1'b0);
    oeN = 1'b1;
    cyc(2);
    check("R4 output enable low blocks", pulses - p0, 0);
    p0 = pulses;
    weN = 1'b0; cyc(10); weN = 1'b1; cyc(8);
    check("R5 chip enable high blocks", pulses - p0, 0);
    p0 = pulses;
    ceN = 1'b0; cyc(10); ceN = 1'b1; cyc(8);
    check("R5 write enable high blocks", pulses - p0, 0);
  endtask

  task automatic t_interrupt();
    int p0 = pulses;
    ceN = 1'b0; weN = 1'b0;
    cyc(MINW - 1);
    oeN = 1'b0; cyc(1); oeN = 1'b1;
    cyc(MINW - 1);
    ceN = 1'b1; weN = 1'b1;
    cyc(8);
    check("R9 dip restarts count", pulses - p0, 0);
  endtask

  task automatic t_drop();
    int p0;
    supplyGood = 1'b0; cyc(3); supplyGood = 1'b1;
    p0 = pulses;
    strobe(10, 1'b0);
    check("R3 strobe after bounce blocked", pulses - p0, 0);
    cyc(HOLD + 10);
    p0 = pulses;
    strobe(10, 1'b0);
    check("R3 strobe after new delay", pulses - p0, 1);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rstN = 1'b1;
    cyc(2);
    t_reset();
    t_unpowered();
    t_holdoff();
    t_width();
    t_long();
    t_order();
    t_levels();
    t_interrupt();
    t_drop();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cyc(20000);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule